// File: doc/BRIEF.md
# Trace Packet Framer

This block turns the raw byte stream arriving from a processor trace port into whole packets. Every byte that is not a continuation of an open packet is taken as a header and sorted into one of twenty packet kinds by a fixed priority of mask-and-compare tests. The kind then decides where the packet ends: branch packets run until a byte with the top bit clear, alignment packets collect zero bytes until a closing 0x80, instruction-sync packets count an optional variable-length cycle count followed by five fixed bytes, and every other kind is one byte long.

Two mechanisms restore alignment on a damaged stream. A five-byte alignment pattern (four zero bytes then 0x80) wins over whatever is half-assembled and is reported at once as a five-byte alignment packet. A silence longer than a set number of byte-times, measured by an external tick, throws the partial packet away so that the next byte is read as a header. A packet that would outgrow the buffer is dropped with an error strobe. The payloads themselves are not interpreted here; a downstream decoder reads the kind, the length and the buffered bytes when the done strobe fires.

Top module: `trace_framer`

## Requirements
- R1: A header byte is classified by the first matching test in this order, giving the `pkt_type` code in brackets: bit 0 set = branch [1]; 0x00 = alignment [2]; 0x04 = cycle count [3]; 0x08 = instruction sync [4]; 0x0C = trigger [5]; (b & 0xF3) in {0x20,0x40,0x60} = out-of-order data [6]; 0x50 = store failed [7]; 0x70 = instruction sync with cycle count [8]; (b & 0xDF) in {0x54,0x58,0x5C} = out-of-order placeholder [9]; 0x3C = virtual machine ID [10]; (b & 0xD3) == 0x02 = data [11]; (b & 0xFB) == 0x42 = timestamp [12]; 0x62 = data suppressed [13]; 0x66 = ignore [14]; (b & 0xEF) == 0x6A = value not traced [15]; 0x6E = context ID [16]; 0x76 = exception exit [17]; 0x7E = exception entry [18]; (b & 0x81) == 0x80 = atom [19]; anything else = unknown [0].
- R2: When an accepted byte completes a packet, `pkt_done` is high for exactly the one cycle after the clock edge that took the byte, with `pkt_type`, `pkt_len` and `pkt_bytes` (byte k of the packet at bits 8k+7:8k, header at k=0) valid in that cycle.
- R3: A branch packet ends at the first of its bytes, the header included, whose bit 7 is clear.
- R4: An alignment packet ends at a byte equal to 0x80; any other byte, zero or not, extends it.
- R5: A header of 0x08 gives a packet of exactly six bytes.
- R6: A header of 0x70 is followed by a cycle count of one to five bytes, ending at a byte with bit 7 clear or at the fifth, then five more bytes; the packet length is 1 + count bytes + 5.
- R7: Every kind other than branch, alignment and the two instruction-sync kinds is a single-byte packet.
- R8: When the last five accepted bytes are 00 00 00 00 80, the partial packet is abandoned and an alignment packet [2] of length 5 holding those bytes completes on that byte.
- R9: A byte that arrives after more than GAP_LIMIT (default 16) gap ticks since the previous byte starts a new packet, discarding any partial one; GAP_LIMIT ticks or fewer leave it intact. A tick in the same cycle as a byte is not counted.
- R10: A byte arriving when DEPTH (default 16) bytes are already buffered without an ending is dropped with the partial packet, `pkt_err` pulses for one cycle and `pkt_done` stays low; a packet that ends at exactly DEPTH bytes completes normally.
- R11: After reset `pkt_done`, `pkt_err` and `pkt_len` are zero and the alignment pattern history holds no zero bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | Trace byte present this cycle |
| byte_in | input | 8 | Trace byte |
| gap_tick | input | 1 | One pulse per byte-time of line silence |
| pkt_done | output | 1 | Packet complete strobe |
| pkt_type | output | 5 | Packet kind code (R1) |
| pkt_len | output | $clog2(DEPTH+1) | Packet length in bytes |
| pkt_bytes | output | 8*DEPTH | Packet bytes, header in the low byte |
| pkt_err | output | 1 | Buffer overflow strobe |

## Verification
Every result of this block appears one clock after the edge that accepts the completing byte: the done and error strobes, kind and length are all registered once, and the byte buffer is written at that same edge. The bench drives each byte at a falling edge, lets one rising edge take it, and samples all outputs one time unit after that edge, before the strobe can fall. Gap ticks are driven only in cycles with no byte, so the silence counted before each byte is exactly the number of tick cycles the test applies.

// File: rtl/trace_pkt_pkg.sv
package trace_pkt_pkg;

    typedef enum logic [4:0] {
        PT_UNKNOWN    = 5'd0,
        PT_BRANCH     = 5'd1,
        PT_ALIGN      = 5'd2,
        PT_CYCCNT     = 5'd3,
        PT_ISYNC      = 5'd4,
        PT_TRIGGER    = 5'd5,
        PT_OOO_DATA   = 5'd6,
        PT_STORE_FAIL = 5'd7,
        PT_ISYNC_CC   = 5'd8,
        PT_OOO_PLACE  = 5'd9,
        PT_VMID       = 5'd10,
        PT_DATA       = 5'd11,
        PT_TSTAMP     = 5'd12,
        PT_DATA_SUPP  = 5'd13,
        PT_IGNORE     = 5'd14,
        PT_NOT_TRACED = 5'd15,
        PT_CTX_ID     = 5'd16,
        PT_EXC_EXIT   = 5'd17,
        PT_EXC_ENTRY  = 5'd18,
        PT_ATOM       = 5'd19
    } pkt_type_e;

    // alignment pattern: (SYNC_LEN-1) zero bytes then the closing byte
    localparam int        SYNC_LEN   = 5;
    localparam logic [7:0] SYNC_LAST = 8'h80;

    // instruction sync: info byte plus address bytes after the header/count
    localparam logic [2:0] ISYNC_TAIL = 3'd5;
    // maximum bytes in the cycle-count field
    localparam logic [2:0] CC_MAX     = 3'd5;

endpackage

// File: rtl/trace_hdr_classify.sv
module trace_hdr_classify
    import trace_pkt_pkg::*;
(
    input  logic [7:0] hdr,
    output pkt_type_e  kind
);
    always_comb begin
        if (hdr[0])                                   kind = PT_BRANCH;
        else if (hdr == 8'h00)                        kind = PT_ALIGN;
        else if (hdr == 8'h04)                        kind = PT_CYCCNT;
        else if (hdr == 8'h08)                        kind = PT_ISYNC;
        else if (hdr == 8'h0C)                        kind = PT_TRIGGER;
        else if ((hdr & 8'hF3) == 8'h20 || (hdr & 8'hF3) == 8'h40 ||
                 (hdr & 8'hF3) == 8'h60)              kind = PT_OOO_DATA;
        else if (hdr == 8'h50)                        kind = PT_STORE_FAIL;
        else if (hdr == 8'h70)                        kind = PT_ISYNC_CC;
        else if ((hdr & 8'hDF) == 8'h54 || (hdr & 8'hDF) == 8'h58 ||
                 (hdr & 8'hDF) == 8'h5C)              kind = PT_OOO_PLACE;
        else if (hdr == 8'h3C)                        kind = PT_VMID;
        else if ((hdr & 8'hD3) == 8'h02)              kind = PT_DATA;
        else if ((hdr & 8'hFB) == 8'h42)              kind = PT_TSTAMP;
        else if (hdr == 8'h62)                        kind = PT_DATA_SUPP;
        else if (hdr == 8'h66)                        kind = PT_IGNORE;
        else if ((hdr & 8'hEF) == 8'h6A)              kind = PT_NOT_TRACED;
        else if (hdr == 8'h6E)                        kind = PT_CTX_ID;
        else if (hdr == 8'h76)                        kind = PT_EXC_EXIT;
        else if (hdr == 8'h7E)                        kind = PT_EXC_ENTRY;
        else if ((hdr & 8'h81) == 8'h80)              kind = PT_ATOM;
        else                                          kind = PT_UNKNOWN;
    end
endmodule

// File: rtl/trace_gap_timer.sv
module trace_gap_timer #(
    parameter int GAP_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_vld,
    input  logic gap_tick,
    output logic expired
);
    localparam int CNT_W = $clog2(GAP_LIMIT + 2);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(GAP_LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (byte_vld)                     cnt_d = '0;
        else if (gap_tick && cnt_q != SAT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == SAT);
endmodule

// File: rtl/trace_sync_detect.sv
module trace_sync_detect
    import trace_pkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output logic       hit
);
    localparam int HW = SYNC_LEN - 1;

    // entry 0 is the most recent byte
    logic [HW-1:0][7:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (byte_vld) hist_d = {hist_q[HW-2:0], byte_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '1;
        else        hist_q <= hist_d;
    end

    assign hit = byte_vld && (hist_q == '0) && (byte_in == SYNC_LAST);
endmodule

// File: rtl/trace_framer.sv
module trace_framer
    import trace_pkt_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int GAP_LIMIT = 16,
    localparam int LEN_W    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_vld,
    input  logic [7:0]         byte_in,
    input  logic               gap_tick,
    output logic               pkt_done,
    output logic [4:0]         pkt_type,
    output logic [LEN_W-1:0]   pkt_len,
    output logic [8*DEPTH-1:0] pkt_bytes,
    output logic               pkt_err
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [LEN_W-1:0] FULL     = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] SYNC_PKT = LEN_W'(SYNC_LEN);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] bytes;
        logic [LEN_W-1:0]      len;
        pkt_type_e             ptype;
        logic                  cc_open;
        logic [2:0]            cc_cnt;
        logic [2:0]            remain;
        logic                  done;
        pkt_type_e             otype;
        logic [LEN_W-1:0]      olen;
        logic                  err;
    } st_t;

    st_t st_d, st_q;

    pkt_type_e        hdr_kind;
    logic             gap_expired;
    logic             sync_hit;
    logic [LEN_W-1:0] cur_len;
    logic [LEN_W-1:0] nxt_len;
    logic             fin;
    pkt_type_e        cur_kind;

    trace_hdr_classify u_cls (
        .hdr  (byte_in),
        .kind (hdr_kind)
    );

    trace_gap_timer #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .gap_tick (gap_tick),
        .expired  (gap_expired)
    );

    trace_sync_detect u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .hit      (sync_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        cur_len  = gap_expired ? '0 : st_q.len;
        nxt_len  = cur_len + 1'b1;
        fin      = 1'b0;
        cur_kind = (cur_len == '0) ? hdr_kind : st_q.ptype;

        if (byte_vld) begin
            if (sync_hit) begin
                // alignment pattern overrides any partial packet
                for (int i = 0; i < SYNC_LEN; i++) begin
                    st_d.bytes[i] = (i == SYNC_LEN - 1) ? SYNC_LAST : 8'h00;
                end
                st_d.len   = '0;
                st_d.done  = 1'b1;
                st_d.otype = PT_ALIGN;
                st_d.olen  = SYNC_PKT;
            end else if (cur_len == FULL) begin
                st_d.len = '0;
                st_d.err = 1'b1;
            end else begin
                st_d.bytes[cur_len[IDX_W-1:0]] = byte_in;
                if (cur_len == '0) begin
                    st_d.ptype = hdr_kind;
                    unique case (hdr_kind)
                        PT_BRANCH:   fin = ~byte_in[7];
                        PT_ALIGN:    fin = 1'b0;
                        PT_ISYNC: begin
                            st_d.cc_open = 1'b0;
                            st_d.remain  = ISYNC_TAIL;
                        end
                        PT_ISYNC_CC: begin
                            st_d.cc_open = 1'b1;
                            st_d.cc_cnt  = '0;
                        end
                        default:     fin = 1'b1;
                    endcase
                end else begin
                    unique case (st_q.ptype)
                        PT_BRANCH: fin = ~byte_in[7];
                        PT_ALIGN:  fin = (byte_in == SYNC_LAST);
                        PT_ISYNC, PT_ISYNC_CC: begin
                            if (st_q.cc_open) begin
                                if (!byte_in[7] || st_q.cc_cnt == CC_MAX - 3'd1) begin
                                    st_d.cc_open = 1'b0;
                                    st_d.remain  = ISYNC_TAIL;
                                end else begin
                                    st_d.cc_cnt = st_q.cc_cnt + 3'd1;
                                end
                            end else begin
                                st_d.remain = st_q.remain - 3'd1;
                                fin         = (st_q.remain == 3'd1);
                            end
                        end
                        default:   fin = 1'b1;
                    endcase
                end
                st_d.len = fin ? '0 : nxt_len;
                if (fin) begin
                    st_d.done  = 1'b1;
                    st_d.otype = cur_kind;
                    st_d.olen  = nxt_len;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_done  = st_q.done;
    assign pkt_type  = st_q.otype;
    assign pkt_len   = st_q.olen;
    assign pkt_bytes = st_q.bytes;
    assign pkt_err   = st_q.err;
endmodule

// File: rtl/trace_framer_chk.sv
module trace_framer_chk
    import trace_pkt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               byte_vld,
    input logic [7:0]         byte_in,
    input logic               pkt_done,
    input logic [4:0]         pkt_type,
    input logic [LEN_W-1:0]   pkt_len,
    input logic [8*DEPTH-1:0] pkt_bytes,
    input logic               pkt_err
);
    // independent record of the last four accepted bytes
    logic [31:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        seen_q <= '1;
        else if (byte_vld) seen_q <= {seen_q[23:0], byte_in};
    end

    logic pattern_now;
    assign pattern_now = byte_vld && seen_q == 32'h0 && byte_in == 8'h80;

    logic [7:0] last_b;
    always_comb begin
        last_b = 8'h00;
        for (int i = 0; i < DEPTH; i++) begin
            if (pkt_len == LEN_W'(i + 1)) last_b = pkt_bytes[i*8 +: 8];
        end
    end

    a_r2_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> $past(byte_vld));

    a_r2_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len != '0 && pkt_len <= LEN_W'(DEPTH)));

    a_r3_branch_ends_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_type == PT_BRANCH) |-> !last_b[7]);

    a_r5_isync_six: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_type == PT_ISYNC) |-> pkt_len == LEN_W'(6));

    a_r7_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_type != PT_BRANCH && pkt_type != PT_ALIGN &&
         pkt_type != PT_ISYNC && pkt_type != PT_ISYNC_CC) |-> pkt_len == LEN_W'(1));

    a_r8_sync_override: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_now |=> (pkt_done && pkt_type == PT_ALIGN && pkt_len == LEN_W'(5)));

    a_r10_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |-> (!pkt_done && $past(byte_vld)));
endmodule

bind trace_framer trace_framer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .pkt_done  (pkt_done),
    .pkt_type  (pkt_type),
    .pkt_len   (pkt_len),
    .pkt_bytes (pkt_bytes),
    .pkt_err   (pkt_err)
);

// File: tb/trace_framer_tb.sv
module trace_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LEN_W      = $clog2(DEPTH + 1);
    localparam int NV         = 44;

    // {byte, expect done, expect type, expect length}
    localparam logic [18:0] VEC [NV] = '{
        {8'h81, 1'b0, 5'd0,  5'd0},   // R3 branch open
        {8'h12, 1'b1, 5'd1,  5'd2},   // R3 branch ends, bit 7 clear
        {8'h04, 1'b1, 5'd3,  5'd1},   // R1 cycle count
        {8'h0C, 1'b1, 5'd5,  5'd1},   // R7 trigger
        {8'h08, 1'b0, 5'd0,  5'd0},   // R5 sync header
        {8'h11, 1'b0, 5'd0,  5'd0},
        {8'h22, 1'b0, 5'd0,  5'd0},
        {8'h33, 1'b0, 5'd0,  5'd0},
        {8'h44, 1'b0, 5'd0,  5'd0},
        {8'h55, 1'b1, 5'd4,  5'd6},   // R5 six bytes
        {8'h70, 1'b0, 5'd0,  5'd0},   // R6 header
        {8'h85, 1'b0, 5'd0,  5'd0},   // R6 count continues
        {8'h01, 1'b0, 5'd0,  5'd0},   // R6 count ends
        {8'hAA, 1'b0, 5'd0,  5'd0},
        {8'h01, 1'b0, 5'd0,  5'd0},
        {8'h02, 1'b0, 5'd0,  5'd0},
        {8'h03, 1'b0, 5'd0,  5'd0},
        {8'h04, 1'b1, 5'd8,  5'd8},   // R6 1+2+5
        {8'h00, 1'b0, 5'd0,  5'd0},   // R4 alignment open
        {8'h00, 1'b0, 5'd0,  5'd0},
        {8'h37, 1'b0, 5'd0,  5'd0},   // R4 non-zero extends
        {8'h80, 1'b1, 5'd2,  5'd4},   // R4 ends on 0x80
        {8'h20, 1'b1, 5'd6,  5'd1},   // R1
        {8'h60, 1'b1, 5'd6,  5'd1},   // R1
        {8'h50, 1'b1, 5'd7,  5'd1},   // R1
        {8'h54, 1'b1, 5'd9,  5'd1},   // R1
        {8'h7C, 1'b1, 5'd9,  5'd1},   // R1
        {8'h3C, 1'b1, 5'd10, 5'd1},   // R1
        {8'h02, 1'b1, 5'd11, 5'd1},   // R1
        {8'h42, 1'b1, 5'd12, 5'd1},   // R1
        {8'h46, 1'b1, 5'd12, 5'd1},   // R1
        {8'h62, 1'b1, 5'd13, 5'd1},   // R1
        {8'h66, 1'b1, 5'd14, 5'd1},   // R1
        {8'h6A, 1'b1, 5'd15, 5'd1},   // R1
        {8'h7A, 1'b1, 5'd15, 5'd1},   // R1
        {8'h6E, 1'b1, 5'd16, 5'd1},   // R1
        {8'h76, 1'b1, 5'd17, 5'd1},   // R7
        {8'h7E, 1'b1, 5'd18, 5'd1},   // R7
        {8'h84, 1'b1, 5'd19, 5'd1},   // R7 atom
        {8'hE0, 1'b1, 5'd19, 5'd1},   // R1 atom
        {8'h10, 1'b1, 5'd0,  5'd1},   // R1 unknown
        {8'h30, 1'b1, 5'd0,  5'd1},   // R1 unknown
        {8'h83, 1'b0, 5'd0,  5'd0},   // R1 branch beats atom
        {8'h03, 1'b1, 5'd1,  5'd2}    // R3
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               byte_vld = 1'b0;
    logic [7:0]         byte_in = 8'h00;
    logic               gap_tick = 1'b0;
    logic               pkt_done;
    logic [4:0]         pkt_type;
    logic [LEN_W-1:0]   pkt_len;
    logic [8*DEPTH-1:0] pkt_bytes;
    logic               pkt_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_framer #(.DEPTH(DEPTH), .GAP_LIMIT(16)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_in   (byte_in),
        .gap_tick  (gap_tick),
        .pkt_done  (pkt_done),
        .pkt_type  (pkt_type),
        .pkt_len   (pkt_len),
        .pkt_bytes (pkt_bytes),
        .pkt_err   (pkt_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one byte in, outputs sampled just after the edge that takes it
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
        @(posedge clk);
        #1;
        byte_vld = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            gap_tick = 1'b1;
            @(negedge clk);
            gap_tick = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 done after reset", 64'(pkt_done), 64'd0);
        chk("R11 err after reset",  64'(pkt_err),  64'd0);
        chk("R11 len after reset",  64'(pkt_len),  64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: 80 straight after reset is not a pattern match
        send(8'h80);
        chk("R11 no sync from reset history", 64'(pkt_type), 64'd19);

        for (int v = 0; v < NV; v++) begin
            send(VEC[v][18:11]);
            chk("R2 vector done", 64'(pkt_done), 64'(VEC[v][10]));
            if (VEC[v][10]) begin
                chk("R1 vector type", 64'(pkt_type), 64'(VEC[v][9:5]));
                chk("R2 vector len",  64'(pkt_len),  64'(VEC[v][4:0]));
            end
        end

        // R2: strobe lasts one cycle
        send(8'h04);
        @(posedge clk); #1;
        chk("R2 done one cycle", 64'(pkt_done), 64'd0);

        // R2 byte placement for a sync packet
        send(8'h08); send(8'hA1); send(8'hB2); send(8'hC3); send(8'hD4); send(8'hE5);
        chk("R2 sync bytes", 64'(pkt_bytes[47:0]), 64'hE5D4C3B2A108);

        // R8 pattern overrides a half-built sync packet
        send(8'h08); send(8'h00); send(8'h00); send(8'h00); send(8'h00);
        chk("R8 no early done", 64'(pkt_done), 64'd0);
        send(8'h80);
        chk("R8 override done", 64'(pkt_done), 64'd1);
        chk("R8 override type", 64'(pkt_type), 64'd2);
        chk("R8 override len",  64'(pkt_len),  64'd5);
        chk("R8 override bytes", 64'(pkt_bytes[39:0]), 64'h8000000000);

        // R8 long zero run still yields a five-byte packet
        for (int i = 0; i < 6; i++) send(8'h00);
        send(8'h80);
        chk("R8 long run len", 64'(pkt_len), 64'd5);

        // R9 gap of 17 ticks discards the open branch
        send(8'h81);
        ticks(17);
        send(8'h04);
        chk("R9 gap discard type", 64'(pkt_type), 64'd3);
        chk("R9 gap discard len",  64'(pkt_len),  64'd1);

        // R9 gap of 16 ticks keeps it
        send(8'h81);
        ticks(16);
        send(8'h04);
        chk("R9 short gap type", 64'(pkt_type), 64'd1);
        chk("R9 short gap len",  64'(pkt_len),  64'd2);

        // R10 branch filling the buffer exactly
        send(8'h81);
        for (int i = 0; i < DEPTH - 2; i++) send(8'hFF);
        send(8'h01);
        chk("R10 full packet done", 64'(pkt_done), 64'd1);
        chk("R10 full packet len",  64'(pkt_len),  64'(DEPTH));
        chk("R10 full last byte", 64'(pkt_bytes[8*DEPTH-1 -: 8]), 64'h01);

        // R10 overflow
        send(8'h81);
        for (int i = 0; i < DEPTH - 1; i++) send(8'hFF);
        chk("R10 not yet err", 64'(pkt_err), 64'd0);
        send(8'hFF);
        chk("R10 err strobe", 64'(pkt_err),  64'd1);
        chk("R10 no done",    64'(pkt_done), 64'd0);
        send(8'h04);
        chk("R10 restart type", 64'(pkt_type), 64'd3);
        chk("R10 restart len",  64'(pkt_len),  64'd1);
        chk("R10 err cleared",  64'(pkt_err),  64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule